// File: doc/BRIEF.md
# Edge-Aligned PWM Time Base with One-Shot Mode

This block is the timing core of a pulse-width modulator. A 15-bit counter runs while an enable flag is set. It counts upward from zero to a programmed period value, and four channel comparators turn the count into raw duty signals. Two strobes are brought out: one marks the cycle in which the count is zero, and the other marks the cycle in which the count equals the period. Later stages take the raw duty signals and add dead time and overrides.

Two kinds of timing are offered. In free-running operation the counter wraps at the period forever, and each channel is high while the count is below that channel's duty value. In one-shot operation every channel goes high in the first cycle after the enable flag is set. Each channel drops when the count reaches its own duty value. When the count reaches the period, all channels drop, the counter returns to zero, the block clears its own enable flag and it sends a single-cycle interrupt. Software sets and clears the enable flag through a write strobe. The mode, the period and the duty values are plain level inputs.

Top module: `pwm_timebase`

## Requirements
- R1: While the enable flag (`en_o`) is low, `cnt_o` is 0, every `duty_o` bit is 0, and both strobes are low.
- R2: In free-running mode (`mode_i` = 2'b00), each enabled cycle moves the count up by one from 0. In the cycle after the count equals `period_i`, the count is back at 0. The first enabled cycle shows count 0.
- R3: In free-running mode, channel i (`duty_i[i*15 +: 15]`) is high exactly while the count is below its duty value. A duty value of 0 gives no high time. A duty value above the period keeps the channel high for the whole period.
- R4: `zero_o` is high in each enabled cycle with count 0. `permatch_o` is high in each enabled cycle whose count equals `period_i`.
- R5: In one-shot mode (`mode_i` = 2'b10), every channel with a nonzero duty value is high from the first enabled cycle. Each channel goes low in the cycle where the count equals its duty value and stays low.
- R6: In one-shot mode, during the cycle where the count equals the period, all channels are low. In the next cycle, the enable flag is low, the count is 0, and `irq_o` is high for exactly one cycle.
- R7: A write that sets the enable flag in the same cycle the block clears it at the one-shot period match is ignored. The flag reads low in the next cycle.
- R8: The mode codes 2'b01 and 2'b11 behave the same as free-running mode.
- R9: A software write of 0 to the enable flag stops the counter. In the next cycle the count is 0 and all channels are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Counting mode: 2'b10 one-shot, all other codes free-running |
| period_i | input | 15 | Period value (last count of a cycle) |
| duty_i | input | 60 | Four duty values, channel i in bits [i*15 +: 15] |
| en_wr_i | input | 1 | Write strobe for the enable flag |
| en_wd_i | input | 1 | Value to write into the enable flag |
| en_o | output | 1 | Current enable flag |
| cnt_o | output | 15 | Current count |
| duty_o | output | 4 | Raw duty signals, one per channel |
| zero_o | output | 1 | Count-is-zero strobe |
| permatch_o | output | 1 | Count-equals-period strobe |
| irq_o | output | 1 | One-cycle interrupt after a one-shot ends |

## Verification
The hardest case to reach is the collision in R7, where a software set of the enable flag arrives in exactly the cycle the one-shot clears it. The stimulus uses a short period of 3. It counts the enabled cycles from the enabling write and places a second enable write on the cycle whose count equals the period. It then checks that the flag, the count and the interrupt in the next cycle are unaffected, and that a later write restarts the pulse cleanly. The duty values 0, equal to the period, and above the period are used in both modes to cover the comparator edges.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    MD_FREE   = 2'b00,
    MD_ALT1   = 2'b01,
    MD_SINGLE = 2'b10,
    MD_ALT3   = 2'b11
  } ptb_mode_e;
endpackage

// File: rtl/ptb_counter.sv
module ptb_counter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          en_wd,
  input  logic          single,
  input  logic [CW-1:0] period,
  output logic          en_q,
  output logic [CW-1:0] cnt_q,
  output logic          zero_hit,
  output logic          per_hit,
  output logic          sp_end,
  output logic          irq_q
);
  // Next count value: wrap to zero at the period, otherwise advance.
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic [CW-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  logic en_nxt;

  assign zero_hit = en_q && (cnt_q == '0);
  assign per_hit  = en_q && (cnt_q == period);
  assign sp_end   = per_hit && single;

  // The self-clear wins over any software write in the same cycle.
  always_comb begin
    en_nxt = en_q;
    if (sp_end)     en_nxt = 1'b0;
    else if (en_wr) en_nxt = en_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      irq_q <= sp_end;
      cnt_q <= (en_q && en_nxt) ? next_count(cnt_q, period) : '0;
    end
  end
endmodule

// File: rtl/ptb_compare.sv
module ptb_compare #(
  parameter int CW  = 15,
  parameter int NCH = 4
) (
  input  logic              en,
  input  logic              single,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     period,
  input  logic [NCH*CW-1:0] duty_flat,
  output logic [NCH-1:0]    raw
);
  // A channel is high below its duty value. In one-shot mode the
  // period-match cycle is forced low.
  function automatic logic chan_on(input logic [CW-1:0] c, input logic [CW-1:0] d,
                                   input logic [CW-1:0] p, input logic s);
    return (c < d) && !(s && (c == p));
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign raw[g] = en && chan_on(cnt, duty_flat[g*CW +: CW], period, single);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW  = 15,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [CW-1:0]     period_i,
  input  logic [NCH*CW-1:0] duty_i,
  input  logic              en_wr_i,
  input  logic              en_wd_i,
  output logic              en_o,
  output logic [CW-1:0]     cnt_o,
  output logic [NCH-1:0]    duty_o,
  output logic              zero_o,
  output logic              permatch_o,
  output logic              irq_o
);
  import ptb_pkg::*;

  logic single_w;
  logic sp_end_w;

  assign single_w = (ptb_mode_e'(mode_i) == MD_SINGLE);

  ptb_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (en_wr_i),
    .en_wd    (en_wd_i),
    .single   (single_w),
    .period   (period_i),
    .en_q     (en_o),
    .cnt_q    (cnt_o),
    .zero_hit (zero_o),
    .per_hit  (permatch_o),
    .sp_end   (sp_end_w),
    .irq_q    (irq_o)
  );

  ptb_compare #(.CW(CW), .NCH(NCH)) u_cmp (
    .en        (en_o),
    .single    (single_w),
    .cnt       (cnt_o),
    .period    (period_i),
    .duty_flat (duty_i),
    .raw       (duty_o)
  );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
  parameter int CW  = 15,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_o,
  input logic [CW-1:0]  cnt_o,
  input logic [NCH-1:0] duty_o,
  input logic           zero_o,
  input logic           permatch_o,
  input logic           irq_o,
  input logic           sp_end
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (cnt_o == '0 && duty_o == '0 && !zero_o && !permatch_o));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(en_o) && !$past(permatch_o)) |-> (cnt_o == CW'($past(cnt_o) + 1'b1)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    permatch_o |=> (cnt_o == '0));

  p_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && !$past(en_o)) |-> zero_o);

  p_end_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_end |-> (duty_o == '0));

  p_end_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_end |=> (!en_o && irq_o));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

bind pwm_timebase ptb_checker #(.CW(CW), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_o       (en_o),
  .cnt_o      (cnt_o),
  .duty_o     (duty_o),
  .zero_o     (zero_o),
  .permatch_o (permatch_o),
  .irq_o      (irq_o),
  .sp_end     (sp_end_w)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  localparam int CW  = 15;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [CW-1:0]     period_i = '0;
  logic [NCH*CW-1:0] duty_i = '0;
  logic              en_wr_i = 1'b0, en_wd_i = 1'b0;
  logic              en_o, zero_o, permatch_o, irq_o;
  logic [CW-1:0]     cnt_o;
  logic [NCH-1:0]    duty_o;

  pwm_timebase #(.CW(CW), .NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .period_i(period_i), .duty_i(duty_i),
    .en_wr_i(en_wr_i), .en_wd_i(en_wd_i), .en_o(en_o), .cnt_o(cnt_o), .duty_o(duty_o),
    .zero_o(zero_o), .permatch_o(permatch_o), .irq_o(irq_o)
  );

  typedef struct {
    string          tag;
    logic           en;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] duty;
    logic           zero, per, irq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  // staged configuration and reference state
  logic [1:0]    s_mode = 2'b00;
  logic [CW-1:0] s_per = '0;
  logic [CW-1:0] s_dv [NCH];
  logic          m_en = 1'b0, m_irq = 1'b0;
  logic [CW-1:0] m_cnt = '0;

  task automatic chk1(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: compares queued expectations just after the driving edge
  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk1(e.tag, "en", int'(en_o), int'(e.en));
      chk1(e.tag, "cnt", int'(cnt_o), int'(e.cnt));
      chk1(e.tag, "duty", int'(duty_o), int'(e.duty));
      chk1(e.tag, "zero", int'(zero_o), int'(e.zero));
      chk1(e.tag, "permatch", int'(permatch_o), int'(e.per));
      chk1(e.tag, "irq", int'(irq_o), int'(e.irq));
    end
  end

  task automatic cfg(input logic [1:0] md, input int per, input int d0, input int d1,
                     input int d2, input int d3);
    s_mode = md;
    s_per = CW'(per);
    s_dv[0] = CW'(d0); s_dv[1] = CW'(d1); s_dv[2] = CW'(d2); s_dv[3] = CW'(d3);
  endtask

  // driver: applies one cycle of stimulus and pushes what the ports must show
  task automatic step(input logic wr, input logic wd, input string tag);
    exp_t e;
    logic one_shot, ends, nen;
    @(negedge clk);
    mode_i = s_mode;
    period_i = s_per;
    for (int i = 0; i < NCH; i++) duty_i[i*CW +: CW] = s_dv[i];
    en_wr_i = wr;
    en_wd_i = wd;
    one_shot = (s_mode == 2'b10);
    e.tag = tag;
    e.en = m_en;
    e.cnt = m_cnt;
    e.irq = m_irq;
    e.zero = m_en && (m_cnt == 0);
    e.per = m_en && (m_cnt == s_per);
    for (int i = 0; i < NCH; i++)
      e.duty[i] = m_en && (m_cnt < s_dv[i]) && !(one_shot && m_cnt == s_per);
    q.push_back(e);
    ends = m_en && one_shot && (m_cnt == s_per);
    nen = ends ? 1'b0 : (wr ? wd : m_en);
    if (!(m_en && nen))       m_cnt = '0;
    else if (m_cnt >= s_per)  m_cnt = '0;
    else                      m_cnt = m_cnt + 1'b1;
    m_en = nen;
    m_irq = ends;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) s_dv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    cfg(2'b00, 5, 0, 2, 5, 9);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R1");

    // R2 R3 R4: free-running, duty 0 / 2 / equal period / above period
    step(1'b1, 1'b1, "R2");
    for (int k = 0; k < 14; k++) step(1'b0, 1'b0, "R3_R4");

    // R9: software stop mid-run
    step(1'b1, 1'b0, "R9");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R9");

    // R8: alternate mode codes behave as free-running
    cfg(2'b01, 3, 1, 3, 0, 7);
    step(1'b1, 1'b1, "R8");
    for (int k = 0; k < 9; k++) step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    cfg(2'b11, 2, 1, 2, 3, 0);
    step(1'b1, 1'b1, "R8");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R1");

    // R5 R6: one-shot, duty 0 / 3 / equal period / above period
    cfg(2'b10, 6, 0, 3, 6, 20);
    step(1'b1, 1'b1, "R5");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, "R5");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R6");

    // R7: set-write collides with the self-clear at the period match
    cfg(2'b10, 3, 2, 3, 9, 1);
    step(1'b1, 1'b1, "R7");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, "R7");
    for (int k = 0; k < 2; k++) step(1'b0, 1'b0, "R7");
    // a later write restarts the pulse
    step(1'b1, 1'b1, "R5");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, "R6");

    @(negedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule